// File: doc/BRIEF.md
# Two-Master Fixed-Priority Bus Arbiter

This block decides which of two masters drives a shared bus: a CPU, which is the default owner and has the lowest priority, and a transfer engine that requests the bus when it is activated. The arbiter moves ownership only when the current owner is between bus cycles. It also waits while the owner holds a lock over a multi-part access, such as a longword carried out as two word cycles. The one exception applies while the CPU is sleeping: a transfer request then takes the bus on the next clock edge, whatever the CPU's cycle state.

Each master reports its own bus activity on three lines. A start pulse opens a cycle. An end pulse marks the last clock of that cycle. A start and an end pulse in the same clock describe a single-clock cycle. A lock level means more parts of the same access follow. A master opens a new cycle only when it has no open cycle. The arbiter keeps one open-cycle flag per master. It derives from that flag whether the bus is at a break, meaning no cycle stays open past the current clock and no lock is held. The two grant outputs are registered. A switch takes effect on the clock edge that ends the cycle in which the break is seen, so no clock passes with neither master granted. All pins are plain control levels or pulses, with no valid/ready streams.

Top module: `bus_arb2`

## Requirements
- R1: While rst_n is low and right after it rises, cpu_gnt is 1, xfer_gnt is 0, and both open-cycle flags are clear.
- R2: Exactly one of cpu_gnt and xfer_gnt is 1 in every clock.
- R3: While the CPU owns the bus and xfer_req is 0, the CPU keeps the grant.
- R4: When the CPU owns the bus, xfer_req is 1 and the CPU is at a break, xfer_gnt becomes 1 on the next rising edge. A break means cpu_lock is 0 and no CPU cycle stays open after this clock.
- R5: While a CPU cycle is open (started and not yet ended), the bus does not pass to the transfer engine unless cpu_sleep is 1.
- R6: While cpu_lock is 1, the bus does not pass to the transfer engine, even in a clock carrying cpu_cyc_end, unless cpu_sleep is 1.
- R7: When the CPU owns the bus and xfer_req and cpu_sleep are both 1, xfer_gnt becomes 1 on the next rising edge, regardless of open cycles or lock.
- R8: The transfer engine keeps the bus while xfer_req is 1. Once xfer_req is 0, the grant returns to the CPU on the edge after the first clock in which the engine is at a break, by the same rule of open cycle and xfer_lock.
- R9: A start pulse opens a cycle and an end pulse closes it. A start and an end pulse in the same clock form a single-clock cycle, and that clock counts as a break.
- R10: A reset asserted during an open cycle abandons it. After reset the CPU is idle, so a pending request takes the bus on the first edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_sleep | input | 1 | CPU is in sleep mode |
| xfer_req | input | 1 | Transfer engine requests the bus |
| cpu_cyc_start | input | 1 | CPU opens a bus cycle this clock |
| cpu_cyc_end | input | 1 | Last clock of the CPU's bus cycle |
| cpu_lock | input | 1 | CPU access continues with further cycles |
| xfer_cyc_start | input | 1 | Transfer engine opens a bus cycle this clock |
| xfer_cyc_end | input | 1 | Last clock of the engine's bus cycle |
| xfer_lock | input | 1 | Engine access continues with further cycles |
| cpu_gnt | output | 1 | Bus granted to the CPU |
| xfer_gnt | output | 1 | Bus granted to the transfer engine |

## Verification
A stuck or stale open-cycle flag shows up at the grant pins one edge after the next request. The handover comes either early, in the middle of a cycle, or late, after the end pulse has passed. A wrong owner state appears on the grant pins at once, because both grants are decoded straight from a single register. Each clock of the random run therefore compares both grants with a model that is built only from the rules above.

// File: rtl/arb2_pkg.sv
package arb2_pkg;
  localparam int unsigned N_MASTERS = 2;
  localparam int unsigned IDX_CPU   = 0;
  localparam int unsigned IDX_XFER  = 1;

  typedef enum logic {
    OWN_CPU  = 1'b0,
    OWN_XFER = 1'b1
  } owner_e;
endpackage

// File: rtl/arb2_cycle_track.sv
module arb2_cycle_track (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_start,
  input  logic cyc_end,
  input  logic lock,
  output logic brk
);
  logic open_q;
  logic open_d;

  assign open_d = (open_q | cyc_start) & ~cyc_end;
  assign brk    = ~lock & ~open_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) open_q <= 1'b0;
    else        open_q <= open_d;
  end

  AST_END_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end |=> !open_q); // R9
  AST_START_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && !cyc_end) |=> open_q); // R9
  AST_OPEN_NO_BRK: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q && !cyc_end) |-> !brk); // R5
endmodule

// File: rtl/arb2_owner_fsm.sv
module arb2_owner_fsm
  import arb2_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_MASTERS-1:0] brk,
  input  logic                 xfer_req,
  input  logic                 cpu_sleep,
  output logic                 cpu_gnt,
  output logic                 xfer_gnt
);
  owner_e own_q;
  owner_e own_d;

  always_comb begin
    own_d = own_q;
    unique case (own_q)
      OWN_CPU:  if (xfer_req && (brk[IDX_CPU] || cpu_sleep)) own_d = OWN_XFER;
      OWN_XFER: if (!xfer_req && brk[IDX_XFER])             own_d = OWN_CPU;
      default:  own_d = OWN_CPU;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) own_q <= OWN_CPU;
    else        own_q <= own_d;
  end

  assign cpu_gnt  = (own_q == OWN_CPU);
  assign xfer_gnt = (own_q == OWN_XFER);

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({cpu_gnt, xfer_gnt})); // R2
  AST_CPU_IDLE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_gnt && !xfer_req) |=> cpu_gnt); // R3
  AST_NO_MIDCYCLE_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_gnt && !brk[IDX_CPU] && !cpu_sleep) |=> cpu_gnt); // R5
  AST_SLEEP_YIELD: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_gnt && xfer_req && cpu_sleep) |=> xfer_gnt); // R7
  AST_XFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_gnt && xfer_req) |=> xfer_gnt); // R8
endmodule

// File: rtl/bus_arb2.sv
module bus_arb2
  import arb2_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_sleep,
  input  logic xfer_req,
  input  logic cpu_cyc_start,
  input  logic cpu_cyc_end,
  input  logic cpu_lock,
  input  logic xfer_cyc_start,
  input  logic xfer_cyc_end,
  input  logic xfer_lock,
  output logic cpu_gnt,
  output logic xfer_gnt
);
  logic [N_MASTERS-1:0] starts;
  logic [N_MASTERS-1:0] ends;
  logic [N_MASTERS-1:0] locks;
  logic [N_MASTERS-1:0] brk;

  assign starts = {xfer_cyc_start, cpu_cyc_start};
  assign ends   = {xfer_cyc_end,   cpu_cyc_end};
  assign locks  = {xfer_lock,      cpu_lock};

  for (genvar m = 0; m < N_MASTERS; m++) begin : g_trk
    arb2_cycle_track u_trk (
      .clk       (clk),
      .rst_n     (rst_n),
      .cyc_start (starts[m]),
      .cyc_end   (ends[m]),
      .lock      (locks[m]),
      .brk       (brk[m])
    );
  end

  arb2_owner_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .brk       (brk),
    .xfer_req  (xfer_req),
    .cpu_sleep (cpu_sleep),
    .cpu_gnt   (cpu_gnt),
    .xfer_gnt  (xfer_gnt)
  );

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_gnt && cpu_lock && !cpu_sleep) |=> cpu_gnt); // R6
  AST_HANDOVER: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_gnt && xfer_req && brk[IDX_CPU]) |=> xfer_gnt); // R4
endmodule

// File: tb/bus_arb2_bench.sv
`timescale 1ns/1ps
module bus_arb2_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_sleep = 0, xfer_req = 0;
  logic cs = 0, ce = 0, cl = 0, xs = 0, xe = 0, xl = 0;
  logic cpu_gnt, xfer_gnt;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // model state
  logic m_own;      // 0 = CPU, 1 = engine
  logic m_copen, m_xopen;

  always #2 clk = ~clk;

  bus_arb2 u_bus_arb2 (
    .clk(clk), .rst_n(rst_n), .cpu_sleep(cpu_sleep), .xfer_req(xfer_req),
    .cpu_cyc_start(cs), .cpu_cyc_end(ce), .cpu_lock(cl),
    .xfer_cyc_start(xs), .xfer_cyc_end(xe), .xfer_lock(xl),
    .cpu_gnt(cpu_gnt), .xfer_gnt(xfer_gnt)
  );

  function automatic logic open_next(logic o, logic s, logic e);
    return (o | s) & ~e;
  endfunction

  function automatic logic at_break(logic o, logic s, logic e, logic l);
    return ~l & ~open_next(o, s, e);
  endfunction

  task automatic check(string tag, logic exp_own);
    n_chk++;
    if (cpu_gnt !== ~exp_own || xfer_gnt !== exp_own) begin
      n_fail++;
      $display("FAIL %s: cpu_gnt=%b xfer_gnt=%b expected cpu_gnt=%b xfer_gnt=%b",
               tag, cpu_gnt, xfer_gnt, ~exp_own, exp_own);
    end
  endtask

  task automatic step(string tag, logic req, logic slp,
                      logic ics, logic ice, logic icl,
                      logic ixs, logic ixe, logic ixl, bit do_chk);
    logic nxt;
    xfer_req = req; cpu_sleep = slp;
    cs = ics; ce = ice; cl = icl; xs = ixs; xe = ixe; xl = ixl;
    nxt = m_own;
    if (!m_own) begin
      if (req && (at_break(m_copen, ics, ice, icl) || slp)) nxt = 1'b1;
    end else begin
      if (!req && at_break(m_xopen, ixs, ixe, ixl)) nxt = 1'b0;
    end
    m_copen = open_next(m_copen, ics, ice);
    m_xopen = open_next(m_xopen, ixs, ixe);
    m_own = nxt;
    @(negedge clk);
    if (do_chk) check(tag, m_own);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    xfer_req = 0; cpu_sleep = 0; cs = 0; ce = 0; cl = 0; xs = 0; xe = 0; xl = 0;
    m_own = 0; m_copen = 0; m_xopen = 0;
    @(negedge clk);
    check("R1 in reset", 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", 1'b0);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    do_reset();

    // R3: no request, CPU busy and idle
    step("R3 idle", 0,0, 0,0,0, 0,0,0, 1);
    step("R3 cpu cycle", 0,0, 1,0,0, 0,0,0, 1);
    step("R3 cpu end", 0,0, 0,1,0, 0,0,0, 1);

    // R5 then R4: request during an open CPU cycle
    step("R5 open", 1,0, 1,0,0, 0,0,0, 1);
    step("R5 still open", 1,0, 0,0,0, 0,0,0, 1);
    step("R4 end handover", 1,0, 0,1,0, 0,0,0, 1);

    // R8: engine holds, return delayed by its open cycle
    step("R8 hold", 1,0, 0,0,0, 1,0,0, 1);
    step("R8 drop while open", 0,0, 0,0,0, 0,0,0, 1);
    step("R8 return at end", 0,0, 0,0,0, 0,1,0, 1);
    step("R8 cpu again", 0,0, 0,0,0, 0,0,0, 1);

    // R8 with engine lock
    step("R8 engine takes", 1,0, 0,0,0, 0,0,0, 1);
    step("R8 lock holds", 0,0, 0,0,0, 1,1,1, 1);
    step("R8 lock released", 0,0, 0,0,0, 1,1,0, 1);

    // R6: CPU lock across a longword
    step("R6 word1", 1,0, 1,1,1, 0,0,0, 1);
    step("R6 word2 open", 1,0, 1,0,1, 0,0,0, 1);
    step("R6 word2 end", 1,0, 0,1,0, 0,0,0, 1);
    step("R4 back", 0,0, 0,0,0, 0,0,0, 1);

    // R7: sleeping CPU with open cycle and lock yields at once
    step("R7 open", 0,0, 1,0,1, 0,0,0, 1);
    step("R7 sleep yield", 1,1, 0,0,1, 0,0,0, 1);
    step("R7 release", 0,0, 0,0,0, 0,0,0, 1);

    // R9: single-clock cycle is a break
    step("R9 single clock", 1,0, 1,1,0, 0,0,0, 1);
    step("R9 back", 0,0, 0,0,0, 0,0,0, 1);

    // R10: reset abandons an open CPU cycle
    step("R10 open", 0,0, 1,0,0, 0,0,0, 1);
    do_reset();
    step("R10 first edge", 1,0, 0,0,0, 0,0,0, 1);
    step("R10 release", 0,0, 0,0,0, 0,0,0, 1);

    // R2: random traffic vs. model
    for (int i = 0; i < 3000; i++) begin
      step("R2 random", ($urandom % 3) != 0, ($urandom % 8) == 0,
           ($urandom % 4) == 0, ($urandom % 3) == 0, ($urandom % 5) == 0,
           ($urandom % 4) == 0, ($urandom % 3) == 0, ($urandom % 5) == 0, 1);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule